// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches a running calendar clock and raises an alarm when the current time agrees with a programmed alarm time. There are four alarm fields: seconds, minutes, hours and day-of-month. Each field has its own alarm register. The top bit of that register is an active-low select bit, and the lower bits hold the BCD value to compare.

The comparison runs once for each one-second update strobe. A field with its select bit at 0 must equal the matching time field. A field with its select bit at 1 is skipped. When every selected field agrees, the alarm flag sets. The flag stays set until the flags register is read.

The select bits set how often the alarm fires:
- seconds only: once a minute;
- seconds and minutes: once an hour;
- seconds, minutes and hours: once a day;
- all four fields: once on one exact date and time;
- no field selected: on every strobe.

Other combinations are not rejected; the alarm fires when all the selected fields agree. An interrupt request follows the flag while the interrupt enable is high.

Top module: `alm_tod_match`

## Requirements
- R1: While reset is held and after reset is released, `alarm_flag` and `alarm_irq` are 0 until a match occurs.
- R2: A field whose alarm register bit 7 is 1 is ignored: its value bits 6:0 may differ from the time field without preventing a match.
- R3: With bit 7 set in all four alarm registers, every `tick_1s` pulse sets `alarm_flag` at the next clock edge.
- R4: A field whose alarm register bit 7 is 0 takes part: if its bits 6:0 differ from the time field, that strobe does not set the flag; if they are equal, it does not prevent the flag from setting.
- R5: The flag sets at the clock edge that samples `tick_1s` high when all selected fields agree, including the case with all four fields selected and equal.
- R6: Without `tick_1s`, a matching time never sets the flag.
- R7: Once set, `alarm_flag` stays 1 until a flags read, whatever the time inputs do.
- R8: A `flags_rd` pulse clears `alarm_flag` at the next edge when no new match is sampled on the same edge.
- R9: When a strobe with a match and a flags read fall on the same edge, the flag ends up 1.
- R10: `alarm_irq` equals `alarm_flag` while `irq_en` is 1, and is 0 while `irq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse for each new second; starts a comparison |
| flags_rd | input | 1 | One-cycle pulse for a read of the flags register; clears the flag |
| irq_en | input | 1 | Alarm interrupt enable |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_date | input | 7 | Current day of month, BCD |
| alm_sec | input | 8 | Seconds alarm register: bit 7 is the ignore bit, bits 6:0 the value |
| alm_min | input | 8 | Minutes alarm register, same layout |
| alm_hour | input | 8 | Hours alarm register, same layout |
| alm_date | input | 8 | Date alarm register, same layout |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Interrupt request |

## Verification
The comparison is tried with four kinds of input:
- All fields ignored. This shows that strobes alone set the flag.
- A single selected field, first with a wrong value and then with the right one. This tells a compared field from an ignored one.
- All four fields selected, with one of them off by one. This shows the fields are ANDed rather than ORed.
- Random time and alarm values drawn from a small range, so that partial matches are common. This shows every mix of selected, ignored, equal and unequal fields against the model.

Directed cycles also cover a match held without a strobe and a read falling on the same edge as a match. Toggling the interrupt enable separates the flag from its gated request.

// File: rtl/alm_pkg.sv
package alm_pkg;
  parameter int NUM_FIELDS = 4;
  parameter int VAL_W      = 7;
  localparam int REG_W     = VAL_W + 1;
  typedef logic [VAL_W-1:0] val_t;
  typedef logic [REG_W-1:0] areg_t;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int VAL_W = alm_pkg::VAL_W
) (
  input  logic             ign,
  input  logic [VAL_W-1:0] alm_val,
  input  logic [VAL_W-1:0] cur_val,
  output logic             hit
);
  logic eq;

  always_comb begin
    eq  = (alm_val == cur_val);
    hit = ign | eq;
  end

  // R4: a selected field that disagrees must block the match
  always_comb begin
    if (!ign && (alm_val != cur_val))
      assert_sel_mismatch_R4: assert (!hit);
  end
endmodule

// File: rtl/alm_flag_reg.sv
module alm_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic all_hit,
  input  logic clr,
  output logic flag
);
  logic set_now;
  logic flag_d;
  logic flag_q;

  always_comb begin
    set_now = tick & all_hit;
    flag_d  = flag_q;
    if (clr)     flag_d = 1'b0;
    if (set_now) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_set_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && all_hit) |=> flag);
  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(tick && all_hit)) |=> !flag);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(tick && all_hit)) |=> $stable(flag));
endmodule

// File: rtl/alm_tod_match.sv
module alm_tod_match #(
  parameter int VAL_W = alm_pkg::VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1s,
  input  logic             flags_rd,
  input  logic             irq_en,
  input  logic [VAL_W-1:0] cur_sec,
  input  logic [VAL_W-1:0] cur_min,
  input  logic [VAL_W-1:0] cur_hour,
  input  logic [VAL_W-1:0] cur_date,
  input  logic [VAL_W:0]   alm_sec,
  input  logic [VAL_W:0]   alm_min,
  input  logic [VAL_W:0]   alm_hour,
  input  logic [VAL_W:0]   alm_date,
  output logic             alarm_flag,
  output logic             alarm_irq
);
  localparam int NF    = alm_pkg::NUM_FIELDS;
  localparam int REG_W = VAL_W + 1;

  logic [VAL_W-1:0] cur_a [NF];
  logic [REG_W-1:0] alm_a [NF];
  logic [NF-1:0]    hit_v;
  logic             all_hit;

  always_comb begin
    cur_a[0] = cur_sec;  alm_a[0] = alm_sec;
    cur_a[1] = cur_min;  alm_a[1] = alm_min;
    cur_a[2] = cur_hour; alm_a[2] = alm_hour;
    cur_a[3] = cur_date; alm_a[3] = alm_date;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_fld
      alm_field_cmp #(.VAL_W(VAL_W)) u_cmp (
        .ign     (alm_a[gi][REG_W-1]),
        .alm_val (alm_a[gi][VAL_W-1:0]),
        .cur_val (cur_a[gi]),
        .hit     (hit_v[gi])
      );
    end
  endgenerate

  assign all_hit = &hit_v;

  alm_flag_reg u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1s),
    .all_hit (all_hit),
    .clr     (flags_rd),
    .flag    (alarm_flag)
  );

  assign alarm_irq = alarm_flag & irq_en;

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en || !alarm_flag) |-> !alarm_irq);
  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && alarm_flag) |-> alarm_irq);
endmodule

// File: tb/sim_alm_tod_match.sv
module sim_alm_tod_match;
  logic clk = 1'b0;
  logic rst_n;
  logic tick_1s, flags_rd, irq_en;
  logic [6:0] cur [4];
  logic [7:0] alm [4];
  logic alarm_flag, alarm_irq;

  int checks = 0;
  int bad = 0;
  bit exp_flag;
  string tag = "R1";

  always #2 clk = ~clk;

  alm_tod_match u0 (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .flags_rd(flags_rd), .irq_en(irq_en),
    .cur_sec(cur[0]), .cur_min(cur[1]), .cur_hour(cur[2]), .cur_date(cur[3]),
    .alm_sec(alm[0]), .alm_min(alm[1]), .alm_hour(alm[2]), .alm_date(alm[3]),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  function automatic bit model_match();
    bit m = 1'b1;
    for (int i = 0; i < 4; i++)
      if (alm[i][7] == 1'b0 && int'(alm[i][6:0]) != int'(cur[i])) m = 1'b0;
    return m;
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_flag = 1'b0;
    else if (tick_1s && model_match()) exp_flag = 1'b1;
    else if (flags_rd) exp_flag = 1'b0;
  end

  task automatic check();
    bit ei = exp_flag && irq_en;
    checks++;
    if (alarm_flag !== exp_flag) begin
      bad++;
      $display("FAIL %s: alarm_flag=%b expected %b at %0t", tag, alarm_flag, exp_flag, $time);
    end
    checks++;
    if (alarm_irq !== ei) begin
      bad++;
      $display("FAIL %s: alarm_irq=%b expected %b at %0t", tag, alarm_irq, ei, $time);
    end
  endtask

  // one clock, checked on the falling edge, strobes dropped afterwards
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    check();
    tick_1s = 1'b0;
    flags_rd = 1'b0;
  endtask

  task automatic expect_flag(input bit v, input string t);
    checks++;
    if (alarm_flag !== v) begin
      bad++;
      $display("FAIL %s: alarm_flag=%b expected %b", t, alarm_flag, v);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: expired, expected completion");
    $display("test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_1s = 1'b0; flags_rd = 1'b0; irq_en = 1'b1;
    for (int i = 0; i < 4; i++) begin cur[i] = 7'h00; alm[i] = 8'h80; end
    tick_1s = 1'b1;
    @(negedge clk); @(negedge clk);
    tag = "R1"; check();
    tick_1s = 1'b0;
    rst_n = 1'b1;
    cyc(); cyc();
    expect_flag(1'b0, "R1");

    // R3: all ignored, every tick sets
    tag = "R3";
    for (int k = 0; k < 3; k++) begin
      cur[0] = 7'(k * 7);
      tick_1s = 1'b1; cyc();
      expect_flag(1'b1, "R3");
      flags_rd = 1'b1; cyc();
      tag = "R8"; expect_flag(1'b0, "R8"); tag = "R3";
    end

    // R6: full match without strobe
    tag = "R6";
    for (int i = 0; i < 4; i++) begin alm[i] = 8'h12; cur[i] = 7'h12; end
    cyc(); cyc(); cyc();
    expect_flag(1'b0, "R6");

    // R4: only seconds selected
    tag = "R4";
    alm[0] = 8'h30; alm[1] = 8'hFF; alm[2] = 8'hFF; alm[3] = 8'hFF;
    cur[0] = 7'h29; tick_1s = 1'b1; cyc();
    expect_flag(1'b0, "R4");
    cur[0] = 7'h30; tick_1s = 1'b1; cyc();
    expect_flag(1'b1, "R4");
    // R7: hold while time moves on
    tag = "R7";
    for (int k = 0; k < 4; k++) begin cur[0] = 7'(k); cur[1] = 7'(k + 3); cyc(); end
    tick_1s = 1'b1; cyc();
    expect_flag(1'b1, "R7");
    flags_rd = 1'b1; cyc();

    // R2: ignored field with different value
    tag = "R2";
    cur[0] = 7'h30; cur[1] = 7'h59; alm[1] = 8'h80 | 8'h05;
    tick_1s = 1'b1; cyc();
    expect_flag(1'b1, "R2");
    flags_rd = 1'b1; cyc();

    // R5: all four selected, one off by one, then exact
    tag = "R5";
    alm[0] = 8'h45; alm[1] = 8'h17; alm[2] = 8'h23; alm[3] = 8'h31;
    cur[0] = 7'h45; cur[1] = 7'h17; cur[2] = 7'h22; cur[3] = 7'h31;
    tick_1s = 1'b1; cyc();
    expect_flag(1'b0, "R5");
    cur[2] = 7'h23; cur[3] = 7'h30;
    tick_1s = 1'b1; cyc();
    expect_flag(1'b0, "R5");
    cur[3] = 7'h31;
    tick_1s = 1'b1; cyc();
    expect_flag(1'b1, "R5");

    // R9: read and match on same edge
    tag = "R9";
    tick_1s = 1'b1; flags_rd = 1'b1; cyc();
    expect_flag(1'b1, "R9");
    // read with tick but no match clears
    cur[0] = 7'h00; tick_1s = 1'b1; flags_rd = 1'b1; cyc();
    tag = "R8"; expect_flag(1'b0, "R8");

    // R10: irq gating
    tag = "R10";
    cur[0] = 7'h45; irq_en = 1'b0; tick_1s = 1'b1; cyc();
    cyc();
    irq_en = 1'b1; cyc();
    irq_en = 1'b0; cyc();
    irq_en = 1'b1; flags_rd = 1'b1; cyc();

    // mixed random patterns, small range so partial matches are frequent
    tag = "R5";
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 4; i++) begin
        cur[i] = 7'($urandom_range(0, 2));
        alm[i] = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 2))};
      end
      tick_1s  = 1'($urandom_range(0, 1));
      flags_rd = ($urandom_range(0, 3) == 0);
      irq_en   = 1'($urandom_range(0, 1));
      cyc();
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule